// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

A purely combinational adder that takes two 20-bit operands and a carry input and returns a 20-bit sum and a carry output. The word is cut into five sections whose widths rise by one bit per section: 2, 3, 4, 5 and 6 bits, starting at the least significant end. Each section works out two results ahead of time. One result assumes that no carry arrives and the other assumes that a carry arrives. The real carry from the section below then picks one of the two through 2-to-1 multiplexers.

Later sections are wider. This gives their two internal ripple chains more time, and they finish at about the moment their select carry settles. The critical path then passes through a number of multiplexers that grows with the square root of the word width, not in a straight line with it. The first section width and the section count are parameters. The word width is derived from them as M·P + P(P-1)/2.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i as an unsigned 21-bit value.
- R2: With the defaults, the sections span bits 0-1, 2-4, 5-8, 9-13 and 14-19. A carry produced at the top of any section reaches every higher section. For example, all-ones plus zero with a carry in gives a zero sum and a set carry out.
- R3: Each bit forms generate = a AND b and propagate = a XOR b in a setup step ahead of the carry logic.
- R4: Each section ripples two carry chains, one started with 0 and one started with 1. At every position the chain started with 1 is set whenever the chain started with 0 is set.
- R5: The carry entering a section selects, bit for bit, between the two precomputed sums and the two precomputed section carries.
- R6: Each sum bit equals its propagate bit XOR the selected carry into that bit. In particular, the carry implied at the lowest bit of each section equals the carry out of the section below, or cin_i for the first section.
- R7: cout_o is the selected carry of the most significant section. It equals generate OR (propagate AND carry-in) at bit 19.
- R8: The result with cin_i = 1 is exactly one more than the result with cin_i = 0 for the same operands, modulo 2^21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 20 | First operand |
| b_i | input | 20 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum bits |
| cout_o | output | 1 | Carry out of bit 19 |

## Verification
The hardest case to reach is a carry that starts in the lowest section and must travel through every select multiplexer to the carry output. Random operands almost never propagate across all twenty bits. The stimulus forces this path with all-ones and long run-of-ones operands, paired with both carry-in values. A reduced six-bit instance of the same structure, with sections of 1, 2 and 3 bits, is swept over every operand and carry combination. This drives every boundary transfer and every multiplexer choice, while random vectors cover the full-width build.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // low bit index of section k when section widths are first_w, first_w+1, ...
  function automatic int sect_lo(input int first_w, input int k);
    return k * first_w + (k * (k - 1)) / 2;
  endfunction

  function automatic int sect_w(input int first_w, input int k);
    return first_w + k;
  endfunction

  function automatic int total_w(input int first_w, input int n_sect);
    return sect_lo(first_w, n_sect);
  endfunction
endpackage

// File: rtl/csa_pg.sv
module csa_pg #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  assign g_o = a_i & b_i;
  assign p_o = a_i ^ b_i;

  always_comb begin
    // generate and propagate never both set (R3)
    assert_pg_exclusive_R3: assert ((g_o & p_o) == '0);
  end
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int   W   = 4,
  parameter logic CIN = 1'b0
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  output logic [W:0]   c_o
);
  assign c_o[0] = CIN;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c_o[i+1] = g_i[i] | (p_i[i] & c_o[i]);
  end
endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o
);
  logic [W-1:0] g, p;
  logic [W:0]   c_lo, c_hi;
  logic [W-1:0] sum_lo, sum_hi;

  csa_pg #(.W(W)) i_pg (
    .a_i(a_i), .b_i(b_i), .g_o(g), .p_o(p)
  );

  csa_ripple #(.W(W), .CIN(1'b0)) i_chain_lo (
    .g_i(g), .p_i(p), .c_o(c_lo)
  );

  csa_ripple #(.W(W), .CIN(1'b1)) i_chain_hi (
    .g_i(g), .p_i(p), .c_o(c_hi)
  );

  assign sum_lo = p ^ c_lo[W-1:0];
  assign sum_hi = p ^ c_hi[W-1:0];

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign sum_o[i] = sel_c_i ? sum_hi[i] : sum_lo[i];
  end
  assign c_o = sel_c_i ? c_hi[W] : c_lo[W];

  always_comb begin
    // assumed-1 chain dominates assumed-0 chain (R4)
    assert_chain_order_R4: assert ((c_lo & ~c_hi) == '0);
    // selected carry-out must agree with the selected sum bits (R5)
    assert_sel_consistent_R5: assert (c_o == (g[W-1] | (p[W-1] & (sum_o[W-1] ^ p[W-1]))));
  end
endmodule

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int FIRST_W = 2,
  parameter int N_SECT  = 5
) (
  input  logic [csa_pkg::total_w(FIRST_W, N_SECT)-1:0] a_i,
  input  logic [csa_pkg::total_w(FIRST_W, N_SECT)-1:0] b_i,
  input  logic                                          cin_i,
  output logic [csa_pkg::total_w(FIRST_W, N_SECT)-1:0] sum_o,
  output logic                                          cout_o
);
  localparam int WIDTH = csa_pkg::total_w(FIRST_W, N_SECT);

  logic [N_SECT:0] sect_c;
  assign sect_c[0] = cin_i;

  for (genvar k = 0; k < N_SECT; k++) begin : g_sect
    localparam int LO = csa_pkg::sect_lo(FIRST_W, k);
    localparam int SW = csa_pkg::sect_w(FIRST_W, k);

    csa_stage #(.W(SW)) i_stage (
      .a_i    (a_i[LO +: SW]),
      .b_i    (b_i[LO +: SW]),
      .sel_c_i(sect_c[k]),
      .sum_o  (sum_o[LO +: SW]),
      .c_o    (sect_c[k+1])
    );

    always_comb begin
      // carry implied at section base matches incoming select carry (R6)
      assert_sect_base_R6: assert ((sum_o[LO] ^ a_i[LO] ^ b_i[LO]) == sect_c[k]);
    end
  end

  assign cout_o = sect_c[N_SECT];

  always_comb begin
    // carry out formed from msb operands and carry implied at msb (R7)
    assert_cout_msb_R7: assert (cout_o ==
      ((a_i[WIDTH-1] & b_i[WIDTH-1]) |
       ((a_i[WIDTH-1] ^ b_i[WIDTH-1]) & (sum_o[WIDTH-1] ^ a_i[WIDTH-1] ^ b_i[WIDTH-1]))));
  end
endmodule

// File: tb/test_sqrt_csel_adder.sv
module test_sqrt_csel_adder;
  localparam int W  = 20;
  localparam int WS = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]  a, b, s;
  logic          ci, co;
  logic [WS-1:0] as, bs, ss;
  logic          cis, cos;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  sqrt_csel_adder i_sqrt_csel_adder (
    .a_i(a), .b_i(b), .cin_i(ci), .sum_o(s), .cout_o(co)
  );

  sqrt_csel_adder #(.FIRST_W(1), .N_SECT(3)) i_sqrt_csel_adder_small (
    .a_i(as), .b_i(bs), .cin_i(cis), .sum_o(ss), .cout_o(cos)
  );

  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
    check(req, {co, s}, ref_add(x, y, c));
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0; as = '0; bs = '0; cis = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // idle operands: zero result
    #1 check("R1 reset zero", {co, s}, '0);

    apply("R1 zeros", '0, '0, 1'b0);
    apply("R1 zeros cin", '0, '0, 1'b1);
    apply("R2 all ones plus one", '1, '0, 1'b1);
    apply("R2 all ones plus ones", '1, '1, 1'b0);
    apply("R2 all ones plus ones cin", '1, '1, 1'b1);
    apply("R3 alternating", 20'h55555, 20'haaaaa, 1'b0);
    apply("R3 alternating cin", 20'h55555, 20'haaaaa, 1'b1);
    apply("R3 same alternating", 20'haaaaa, 20'haaaaa, 1'b1);
    // carry born at each section top, crosses upward (bits 1,4,8,13)
    apply("R2 boundary 1", 20'h00003, 20'h00001, 1'b0);
    apply("R2 boundary 4", 20'hfffff, 20'h00010, 1'b0);
    apply("R6 boundary 8", 20'h001ff, 20'h00100, 1'b0);
    apply("R7 boundary 13", 20'h03fff, 20'hfe000, 1'b0);
    apply("R7 msb generate", 20'h80000, 20'h80000, 1'b0);

    // R8: cin adds exactly one
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] x, y;
      logic [W:0]   r0, r1;
      x = W'($urandom); y = W'($urandom);
      if (i < 20) y = ~x;
      @(negedge clk); a = x; b = y; ci = 1'b0; #1 r0 = {co, s};
      @(negedge clk); ci = 1'b1; #1 r1 = {co, s};
      check("R8 cin increments", r1, r0 + 1'b1);
    end

    // R1/R4/R5 random full width, with run-of-ones bias
    for (int i = 0; i < 8000; i++) begin
      logic [W-1:0] x, y;
      x = W'($urandom); y = W'($urandom);
      if (i % 4 == 0) y = ~x ^ (W'(1) << ($urandom % W));
      apply("R1 random", x, y, 1'($urandom));
    end

    // R5/R6 exhaustive on reduced build
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < (1 << WS); x++) begin
        for (int y = 0; y < (1 << WS); y++) begin
          logic [WS:0] e;
          @(negedge clk);
          as = WS'(x); bs = WS'(y); cis = 1'(c);
          #1;
          e = (WS+1)'(x + y + c);
          checks++;
          if ({cos, ss} !== e) begin
            errors++;
            $display("FAIL R5 small %0d+%0d+%0d got %h expected %h", x, y, c, {cos, ss}, e);
          end
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule